// File: doc/BRIEF.md
# Memory ordering issue controller

This block stands between the in-order stream of memory requests from one processor and a memory port that can keep several accesses in flight. Each request is presented with a valid/ready handshake and carries an access type. The block looks at the outstanding accesses and decides whether the request at the head of the stream may go out this cycle. A request that is accepted appears on the issue outputs in the same cycle.

The ordering rules come from a consistency model picked at run time by a mode input. The models are sequential, processor, weak and release consistency. Four counters track the accesses still in flight: ordinary reads, ordinary writes, synchronization/acquire accesses, and releases. A completion input reports the type of each finished access and decrements the matching counter. A new mode value takes effect only once nothing is outstanding.

Top module: `mem_order_gate`

## Requirements
- R1: Access type codes: 0 ordinary read, 1 ordinary write, 2 synchronization, 3 acquire, 4 release. Mode codes: 0 sequential, 1 processor, 2 weak, 3 release. After reset nothing is outstanding, and a request of any type is accepted at once.
- R2: In mode 0, no request is accepted while any access of any type is outstanding.
- R3: In mode 1, an ordinary read is accepted when no read is outstanding, even if writes are still outstanding.
- R4: In mode 1, a write, synchronization, acquire or release request is accepted only when nothing at all is outstanding.
- R5: In mode 2, an ordinary read or write waits while any synchronization, acquire or release access is outstanding. Outstanding ordinary accesses do not hold it back.
- R6: In mode 2, a synchronization, acquire or release request waits until nothing of any type is outstanding.
- R7: In mode 3, ordinary reads and writes, and synchronization and acquire requests, wait only while a synchronization or acquire access is outstanding.
- R8: In mode 3, a release waits while any ordinary read, ordinary write or earlier release is outstanding. Outstanding acquires do not hold it back.
- R9: Each of the four counters holds at most 15. A request whose counter is at 15 is held with ready low.
- R10: A completion decrements its counter in the same edge in which an issue increments it. An issue and a completion on the same counter in one cycle leave the counter unchanged.
- R11: The mode input is taken only while nothing is outstanding. While accesses are outstanding and the mode input differs from the active mode, ready stays low until they drain, and then the new mode applies.
- R12: The issue strobe is high exactly in cycles where valid and ready are both high, and the issued type equals the request type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Requested consistency model |
| req_valid | input | 1 | Request present |
| req_type | input | 3 | Request access type |
| req_ready | output | 1 | Request may issue this cycle |
| iss_valid | output | 1 | Access issued to memory port |
| iss_type | output | 3 | Type of the issued access |
| cmp_valid | input | 1 | An outstanding access has completed |
| cmp_type | input | 3 | Type of the completed access |

## Verification
The assertions assume two things about the inputs. Every completion refers to an access of that type that is really outstanding, and type codes stay in the range 0 to 4. The random stimulus keeps to this. It draws request types only from the five legal codes. It raises a completion only for a counter that the bench's own model shows as nonzero. Directed sequences fill a counter to its limit, pair an issue with a completion on the same counter, and change the mode while accesses are in flight.

// File: rtl/mem_order_gate.sv
module mem_order_gate #(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       req_valid,
  input  logic [2:0] req_type,
  output logic       req_ready,
  output logic       iss_valid,
  output logic [2:0] iss_type,
  input  logic       cmp_valid,
  input  logic [2:0] cmp_type
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] rd_cnt, wr_cnt, sy_cnt, rl_cnt;
  logic [1:0]    mode_q;

  wire idle = (rd_cnt == '0) && (wr_cnt == '0) && (sy_cnt == '0) && (rl_cnt == '0);
  wire [1:0] mode_e = idle ? mode_i : mode_q;
  wire mode_hold = !idle && (mode_i != mode_q);

  wire t_rd = (req_type == 3'd0);
  wire t_wr = (req_type == 3'd1);
  wire t_sy = (req_type == 3'd2) || (req_type == 3'd3);
  wire t_rl = (req_type == 3'd4);

  wire c_rd = cmp_valid && (cmp_type == 3'd0);
  wire c_wr = cmp_valid && (cmp_type == 3'd1);
  wire c_sy = cmp_valid && ((cmp_type == 3'd2) || (cmp_type == 3'd3));
  wire c_rl = cmp_valid && (cmp_type == 3'd4);

  wire no_sy = (sy_cnt == '0);
  wire no_rl = (rl_cnt == '0);
  wire no_ord = (rd_cnt == '0) && (wr_cnt == '0);

  logic rule_ok;
  always_comb begin
    unique case (mode_e)
      2'd0: rule_ok = idle;
      2'd1: rule_ok = t_rd ? (rd_cnt == '0) : idle;
      2'd2: rule_ok = (t_rd || t_wr) ? (no_sy && no_rl) : idle;
      default: rule_ok = t_rl ? (no_ord && no_rl) : no_sy;
    endcase
  end

  wire full = (t_rd && rd_cnt == CMAX) || (t_wr && wr_cnt == CMAX) ||
              (t_sy && sy_cnt == CMAX) || (t_rl && rl_cnt == CMAX);

  assign req_ready = rule_ok && !full && !mode_hold;
  assign iss_valid = req_valid && req_ready;
  assign iss_type  = req_type;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic up, input logic dn);
    step = c + {{(CW-1){1'b0}}, up} - {{(CW-1){1'b0}}, dn};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
      sy_cnt <= '0;
      rl_cnt <= '0;
      mode_q <= 2'd0;
    end else begin
      rd_cnt <= step(rd_cnt, iss_valid && t_rd, c_rd);
      wr_cnt <= step(wr_cnt, iss_valid && t_wr, c_wr);
      sy_cnt <= step(sy_cnt, iss_valid && t_sy, c_sy);
      rl_cnt <= step(rl_cnt, iss_valid && t_rl, c_rl);
      if (idle) mode_q <= mode_i;
    end
  end
endmodule

module mem_order_gate_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic [2:0]    iss_type,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] rd_cnt,
  input logic [CW-1:0] wr_cnt,
  input logic [CW-1:0] sy_cnt,
  input logic [CW-1:0] rl_cnt
);
  wire busy = (rd_cnt != '0) || (wr_cnt != '0) || (sy_cnt != '0) || (rl_cnt != '0);

  AST_SC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && busy && mode_q == 2'd0) |-> 1'b0); // R2
  AST_PC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && mode_q == 2'd1 && iss_type == 3'd0) |-> (rd_cnt == '0)); // R3
  AST_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && mode_q == 2'd3 && iss_type == 3'd4) |-> (rd_cnt == '0 && wr_cnt == '0 && rl_cnt == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == '1) |=> (rd_cnt != '0)); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (mode_q == $past(mode_q))); // R11
endmodule

bind mem_order_gate mem_order_gate_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_type(iss_type),
  .mode_q(mode_q), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .sy_cnt(sy_cnt), .rl_cnt(rl_cnt)
);

// File: tb/mem_order_gate_bench.sv
module mem_order_gate_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_i = 0;
  logic req_valid = 0, cmp_valid = 0;
  logic [2:0] req_type = 0, cmp_type = 0;
  logic req_ready, iss_valid;
  logic [2:0] iss_type;

  int n_chk = 0, n_bad = 0;
  int m_rd, m_wr, m_sy, m_rl, m_mode;

  always #2 clk = ~clk;

  mem_order_gate u_mem_order_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_valid(req_valid),
    .req_type(req_type), .req_ready(req_ready), .iss_valid(iss_valid),
    .iss_type(iss_type), .cmp_valid(cmp_valid), .cmp_type(cmp_type));

  function automatic bit exp_ready(input int t, input int md);
    bit idle, ok, full;
    int e;
    idle = (m_rd == 0 && m_wr == 0 && m_sy == 0 && m_rl == 0);
    e = idle ? md : m_mode;
    case (e)
      0: ok = idle;
      1: ok = (t == 0) ? (m_rd == 0) : idle;
      2: ok = (t <= 1) ? (m_sy == 0 && m_rl == 0) : idle;
      default: ok = (t == 4) ? (m_rd == 0 && m_wr == 0 && m_rl == 0) : (m_sy == 0);
    endcase
    full = (t == 0 && m_rd == 15) || (t == 1 && m_wr == 15) ||
           ((t == 2 || t == 3) && m_sy == 15) || (t == 4 && m_rl == 15);
    return ok && !full && !(!idle && md != m_mode);
  endfunction

  function automatic string tag_of(input int t, input int md);
    bit idle;
    idle = (m_rd == 0 && m_wr == 0 && m_sy == 0 && m_rl == 0);
    if (idle) return "R1";
    if (md != m_mode) return "R11";
    case (m_mode)
      0: return "R2";
      1: return (t == 0) ? "R3" : "R4";
      2: return (t <= 1) ? "R5" : "R6";
      default: return (t == 4) ? "R8" : "R7";
    endcase
  endfunction

  task automatic cycle(input bit v, input int t, input bit cv, input int ct, input int md, input string tg);
    bit er;
    string tt;
    @(negedge clk);
    req_valid = v; req_type = 3'(t); cmp_valid = cv; cmp_type = 3'(ct); mode_i = 2'(md);
    #1;
    er = exp_ready(t, md);
    tt = (tg == "") ? tag_of(t, md) : tg;
    n_chk++;
    if (req_ready !== er) begin
      n_bad++;
      $display("FAIL %s ready act=%0b exp=%0b (rd%0d wr%0d sy%0d rl%0d mode%0d type%0d)",
               tt, req_ready, er, m_rd, m_wr, m_sy, m_rl, m_mode, t);
    end
    n_chk++;
    if (iss_valid !== (v && er) || iss_type !== 3'(t)) begin
      n_bad++;
      $display("FAIL R12 issue act=%0b/%0d exp=%0b/%0d", iss_valid, iss_type, v && er, t);
    end
    if (m_rd == 0 && m_wr == 0 && m_sy == 0 && m_rl == 0) m_mode = md;
    if (v && er) begin
      if (t == 0) m_rd++; else if (t == 1) m_wr++; else if (t == 4) m_rl++; else m_sy++;
    end
    if (cv) begin
      if (ct == 0) m_rd--; else if (ct == 1) m_wr--; else if (ct == 4) m_rl--; else m_sy--;
    end
  endtask

  task automatic drain(input int md);
    while (m_rd > 0) cycle(0, 0, 1, 0, md, "R10");
    while (m_wr > 0) cycle(0, 0, 1, 1, md, "R10");
    while (m_sy > 0) cycle(0, 0, 1, 3, md, "R10");
    while (m_rl > 0) cycle(0, 0, 1, 4, md, "R10");
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_rd = 0; m_wr = 0; m_sy = 0; m_rl = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state accepts any type
    for (int t = 0; t < 5; t++) cycle(1, t, 0, 0, 0, "R1");
    drain(0);
    // R2: sequential blocks after a write
    cycle(1, 1, 0, 0, 0, "R2");
    cycle(1, 0, 0, 0, 0, "R2");
    cycle(1, 0, 1, 1, 0, "R2");
    drain(0);
    // R3/R4: processor mode, read bypasses write, write waits
    cycle(1, 1, 0, 0, 1, "R4");
    cycle(1, 0, 0, 0, 1, "R3");
    cycle(1, 0, 0, 0, 1, "R3");
    cycle(1, 1, 0, 0, 1, "R4");
    drain(1);
    // R9/R10: weak mode fill reads to the limit
    for (int i = 0; i < 16; i++) cycle(1, 0, 0, 0, 2, "R9");
    cycle(1, 0, 1, 0, 2, "R9");
    cycle(1, 0, 1, 0, 2, "R10");
    cycle(1, 0, 1, 0, 2, "R10");
    cycle(1, 2, 0, 0, 2, "R6");
    // R11: mode change held while busy
    cycle(1, 0, 0, 0, 3, "R11");
    drain(3);
    // R7/R8: release mode
    cycle(1, 3, 0, 0, 3, "R7");
    cycle(1, 4, 0, 0, 3, "R8");
    cycle(1, 0, 0, 0, 3, "R7");
    cycle(1, 3, 1, 3, 3, "R7");
    cycle(1, 0, 0, 0, 3, "R7");
    cycle(1, 4, 0, 0, 3, "R8");
    drain(3);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      int t, md, ct;
      bit cv;
      md = ($urandom % 64 == 0) ? int'($urandom % 4) : m_mode;
      t = $urandom % 5;
      ct = $urandom % 5;
      cv = ($urandom % 3 != 0);
      if (ct == 0 && m_rd == 0) cv = 0;
      if (ct == 1 && m_wr == 0) cv = 0;
      if ((ct == 2 || ct == 3) && m_sy == 0) cv = 0;
      if (ct == 4 && m_rl == 0) cv = 0;
      cycle($urandom % 4 != 0, t, cv, ct, md, "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule